// File: doc/BRIEF.md
# Bidirectional Parallel Port Controller

This block is the host side of a byte-wide parallel port. A processor reaches it through a small I/O-mapped register window: an address, a write strobe, a read strobe and an 8-bit data bus. The window has three registers. The data register holds the byte driven onto the connector. The status register is read-only and shows the five device status lines. The control register drives four connector control lines. It also sets the data direction and enables the interrupt.

Register bits and connector pin levels do not have one common polarity. Some control outputs are inverted and one is not. One status input reads inverted. When the direction bit is set, the data lines are released and a data read returns what the attached device drives. The acknowledge line is passed to an interrupt request output only when the interrupt-enable bit is set. All connector inputs pass through a synchronizer before the register read path or the interrupt logic sees them. The data pins come out as separate output, output-enable and input vectors, so the pad ring owns the actual tri-state buffer.

Top module: `lpt_host_port`

## Requirements
- R1: A write to offset 0 latches the byte onto `pd_out` at the next clock edge. While control bit 5 is 0, `pd_oe` is 1 and a read of offset 0 returns the latched byte.
- R2: While control bit 5 is 1, `pd_oe` is 0 and a read of offset 0 returns the synchronized levels on `pd_in`. The latched byte is kept and comes back when bit 5 returns to 0.
- R3: A read of offset 1 returns bit 3 = error pin, bit 4 = select pin, bit 5 = paper-empty pin, bit 6 = acknowledge pin, bit 7 = inverse of the busy pin, and bits 0 to 2 = 0.
- R4: Control bit 0 drives `pin_strobe`, bit 1 drives `pin_autofeed` and bit 3 drives `pin_selin`, each inverted (register 1 gives a low pin). Bit 2 drives `pin_init` non-inverted.
- R5: With control bit 4 at 1, `irq_out` follows the synchronized acknowledge pin. With bit 4 at 0, `irq_out` is 0. In the default variant `irq_oe` is always 1. In the tri-state variant `irq_oe` equals bit 4.
- R6: A read of offset 2 returns all eight control bits exactly as last written, including bits 6 and 7, which drive no pin.
- R7: After reset the data latch and the control register are 0x00. So `pd_oe`=1, `pd_out`=0x00, strobe, auto-feed and select-in are high, init is low and `irq_out` is 0.
- R8: A change on a status or data input shows up in register reads after SYNC_STAGES rising edges and not earlier.
- R9: A write to offset 1 changes nothing. A read of any offset above 2 returns 0x00, and a write to such an offset changes no register or pin.
- R10: `bus_rdata` is 0x00 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pd_out | output | 8 | Data pin output levels |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Data pin input levels |
| pin_strobe | output | 1 | Strobe output pin |
| pin_autofeed | output | 1 | Auto-feed output pin |
| pin_init | output | 1 | Initialize output pin |
| pin_selin | output | 1 | Select-in output pin |
| pin_error | input | 1 | Error status pin |
| pin_select | input | 1 | Select status pin |
| pin_paper | input | 1 | Paper-empty status pin |
| pin_ack | input | 1 | Acknowledge status pin |
| pin_busy | input | 1 | Busy status pin |
| irq_out | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The bench builds the block with its defaults: a 4-bit offset, two synchronizer stages and the driven-low interrupt variant. The 4-bit offset lets the bench reach unused offsets 3 and 15 and check that they read zero and ignore writes. Two stages make the synchronizer latency short enough to check at both edges: the value after one edge is still the old one, and after two it is the new one. Each status pin is set high alone, so a swapped bit position or a lost inversion shows up on its own.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   // Register offsets inside the window
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_CTRL = 2;

   // Control register bit positions
   localparam int unsigned CB_STROBE = 0;
   localparam int unsigned CB_AFEED  = 1;
   localparam int unsigned CB_INIT   = 2;
   localparam int unsigned CB_SELIN  = 3;
   localparam int unsigned CB_IRQEN  = 4;
   localparam int unsigned CB_DIR    = 5;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned NUM_STAT  = 5;

   // Synchronized connector inputs
   typedef struct packed {
      logic busy;
      logic ack;
      logic paper;
      logic select;
      logic error;
   } stat_pins_t;

   // Status byte layout: bit 7 busy (inverted), 6 ack, 5 paper, 4 select, 3 error
   function automatic logic [BYTE_W-1:0] pack_status(stat_pins_t s);
      return {~s.busy, s.ack, s.paper, s.select, s.error, 3'b000};
   endfunction
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
   parameter int unsigned WIDTH  = 13,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpt_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lpt_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  stat_pins_t        stat_s,
   input  logic [BYTE_W-1:0] pd_in_s,
   output logic [BYTE_W-1:0] data_q,
   output logic [BYTE_W-1:0] ctrl_q
);
   localparam int unsigned WINDOW = 1 << ADDR_W;

   generate
      if (WINDOW <= OFS_CTRL) begin : g_bad_addr
         $error("lpt_regs: ADDR_W too small to reach the control offset");
      end
   endgenerate

   logic sel_data, sel_stat, sel_ctrl;
   assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
      end else if (bus_wr) begin
         if (sel_data) data_q <= bus_wdata;
         if (sel_ctrl) ctrl_q <= bus_wdata;
      end
   end

   logic [BYTE_W-1:0] data_view;
   assign data_view = ctrl_q[CB_DIR] ? pd_in_s : data_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_data)      bus_rdata = data_view;
         else if (sel_stat) bus_rdata = pack_status(stat_s);
         else if (sel_ctrl) bus_rdata = ctrl_q;
      end
   end

   // Write to status offset leaves both stored registers unchanged
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_stat) |=> ($stable(data_q) && $stable(ctrl_q))); // R9

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0)); // R10
endmodule

// File: rtl/lpt_pins.sv
module lpt_pins
   import lpt_pkg::*;
#(
   parameter bit IRQ_TRISTATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] data_q,
   input  logic [5:0]        ctrl_pin_bits,
   input  logic              ack_s,
   output logic [BYTE_W-1:0] pd_out,
   output logic              pd_oe,
   output logic              pin_strobe,
   output logic              pin_autofeed,
   output logic              pin_init,
   output logic              pin_selin,
   output logic              irq_out,
   output logic              irq_oe
);
   assign pd_out       = data_q;
   assign pd_oe        = ~ctrl_pin_bits[CB_DIR];
   assign pin_strobe   = ~ctrl_pin_bits[CB_STROBE];
   assign pin_autofeed = ~ctrl_pin_bits[CB_AFEED];
   assign pin_init     =  ctrl_pin_bits[CB_INIT];
   assign pin_selin    = ~ctrl_pin_bits[CB_SELIN];

   generate
      if (IRQ_TRISTATE) begin : g_irq_tri
         assign irq_out = ack_s;
         assign irq_oe  = ctrl_pin_bits[CB_IRQEN];
      end else begin : g_irq_low
         assign irq_out = ack_s & ctrl_pin_bits[CB_IRQEN];
         assign irq_oe  = 1'b1;
      end
   endgenerate

   logic irq_active;
   assign irq_active = irq_out & irq_oe;

   AST_IRQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_active |-> ack_s); // R5
endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          IRQ_TRISTATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [7:0]        pd_out,
   output logic              pd_oe,
   input  logic [7:0]        pd_in,
   output logic              pin_strobe,
   output logic              pin_autofeed,
   output logic              pin_init,
   output logic              pin_selin,
   input  logic              pin_error,
   input  logic              pin_select,
   input  logic              pin_paper,
   input  logic              pin_ack,
   input  logic              pin_busy,
   output logic              irq_out,
   output logic              irq_oe
);
   localparam int unsigned SYNC_W = BYTE_W + NUM_STAT;

   stat_pins_t        stat_raw, stat_s;
   logic [BYTE_W-1:0] pd_in_s;
   logic [SYNC_W-1:0] sync_in, sync_out;
   logic [BYTE_W-1:0] data_q, ctrl_q;

   assign stat_raw = '{busy: pin_busy, ack: pin_ack, paper: pin_paper,
                       select: pin_select, error: pin_error};
   assign sync_in  = {stat_raw, pd_in};
   assign {stat_s, pd_in_s} = sync_out;

   lpt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(sync_in), .d_sync(sync_out)
   );

   lpt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .stat_s(stat_s), .pd_in_s(pd_in_s),
      .data_q(data_q), .ctrl_q(ctrl_q)
   );

   lpt_pins #(.IRQ_TRISTATE(IRQ_TRISTATE)) u_pins (
      .clk(clk), .rst_n(rst_n),
      .data_q(data_q), .ctrl_pin_bits(ctrl_q[5:0]), .ack_s(stat_s.ack),
      .pd_out(pd_out), .pd_oe(pd_oe),
      .pin_strobe(pin_strobe), .pin_autofeed(pin_autofeed),
      .pin_init(pin_init), .pin_selin(pin_selin),
      .irq_out(irq_out), .irq_oe(irq_oe)
   );

   logic wr_data, wr_ctrl, wr_high;
   assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_high = bus_wr && (bus_addr > ADDR_W'(OFS_CTRL));

   AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (pd_out == $past(bus_wdata))); // R1

   AST_DIR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (pd_oe == !$past(bus_wdata[CB_DIR]))); // R2

   AST_CTRL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ((pin_strobe == !$past(bus_wdata[CB_STROBE])) &&
                   (pin_autofeed == !$past(bus_wdata[CB_AFEED])) &&
                   (pin_selin == !$past(bus_wdata[CB_SELIN])) &&
                   (pin_init == $past(bus_wdata[CB_INIT])))); // R4

   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (!bus_rd || (bus_addr != ADDR_W'(OFS_CTRL)) ||
                   (bus_rdata == $past(bus_wdata)))); // R6

   AST_HIGH_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_high |=> ($stable(pd_out) && $stable(pd_oe) && $stable(pin_strobe) &&
                   $stable(pin_init) && $stable(irq_oe))); // R9

   AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[CB_IRQEN]) |=> !(irq_out && irq_oe)); // R5
endmodule

// File: tb/lpt_host_port_tb.sv
module lpt_host_port_tb;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0, bus_rdata;
   logic [7:0]    pd_out, pd_in = '0;
   logic          pd_oe, pin_strobe, pin_autofeed, pin_init, pin_selin;
   logic          pin_error = 0, pin_select = 0, pin_paper = 0, pin_ack = 0, pin_busy = 0;
   logic          irq_out, irq_oe;

   int n_cmp = 0, n_bad = 0;

   always #4 clk = ~clk;  // 125 MHz

   lpt_host_port #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
      .pd_in(pd_in), .pin_strobe(pin_strobe), .pin_autofeed(pin_autofeed),
      .pin_init(pin_init), .pin_selin(pin_selin), .pin_error(pin_error),
      .pin_select(pin_select), .pin_paper(pin_paper), .pin_ack(pin_ack),
      .pin_busy(pin_busy), .irq_out(irq_out), .irq_oe(irq_oe)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // Combinational read, sampled mid-cycle
   task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R7 pd_out", pd_out, 8'h00);
      check("R7 pd_oe", {7'd0, pd_oe}, 8'h01);
      check("R7 ctl pins", {4'd0, pin_strobe, pin_autofeed, pin_init, pin_selin}, 8'h0D);
      check("R7 irq", {7'd0, irq_out}, 8'h00);
      rd(2, v); check("R7 ctrl reg", v, 8'h00);
      #1 check("R10 idle rdata", bus_rdata, 8'h00);
   endtask

   task automatic t_data_out();
      logic [7:0] v;
      wr(0, 8'hA5);
      check("R1 pd_out", pd_out, 8'hA5);
      pd_in = 8'h3C;
      rd(0, v); check("R1 readback latch", v, 8'hA5);
      wr(0, 8'h5A);
      rd(0, v); check("R1 second byte", v, 8'h5A);
   endtask

   task automatic t_dir_in();
      logic [7:0] v;
      wr(2, 8'h20);
      check("R2 oe released", {7'd0, pd_oe}, 8'h00);
      pd_in = 8'hC3;
      repeat (3) @(negedge clk);
      rd(0, v); check("R2 pin read", v, 8'hC3);
      wr(2, 8'h00);
      rd(0, v); check("R2 latch kept", v, 8'h5A);
      check("R2 oe back", {7'd0, pd_oe}, 8'h01);
   endtask

   task automatic t_status();
      logic [7:0] v;
      // each pin alone; busy low reads as 1 in bit 7
      pin_error = 1; repeat (3) @(negedge clk);
      rd(1, v); check("R3 error bit3", v, 8'h88);
      pin_error = 0; pin_select = 1; repeat (3) @(negedge clk);
      rd(1, v); check("R3 select bit4", v, 8'h90);
      pin_select = 0; pin_paper = 1; repeat (3) @(negedge clk);
      rd(1, v); check("R3 paper bit5", v, 8'hA0);
      pin_paper = 0; pin_ack = 1; repeat (3) @(negedge clk);
      rd(1, v); check("R3 ack bit6", v, 8'hC0);
      pin_ack = 0; pin_busy = 1; repeat (3) @(negedge clk);
      rd(1, v); check("R3 busy inverted", v, 8'h00);
      pin_busy = 0; repeat (3) @(negedge clk);
   endtask

   task automatic t_ctrl_pins();
      logic [7:0] v;
      wr(2, 8'h01);
      check("R4 strobe", {4'd0, pin_strobe, pin_autofeed, pin_init, pin_selin}, 8'h05);
      wr(2, 8'h02);
      check("R4 autofeed", {4'd0, pin_strobe, pin_autofeed, pin_init, pin_selin}, 8'h09);
      wr(2, 8'h04);
      check("R4 init", {4'd0, pin_strobe, pin_autofeed, pin_init, pin_selin}, 8'h0F);
      wr(2, 8'h08);
      check("R4 selin", {4'd0, pin_strobe, pin_autofeed, pin_init, pin_selin}, 8'h0C);
      wr(2, 8'hCB);
      rd(2, v); check("R6 readback", v, 8'hCB);
      wr(2, 8'h00);
   endtask

   task automatic t_irq();
      wr(2, 8'h10);
      pin_ack = 1; repeat (3) @(negedge clk);
      check("R5 irq on", {6'd0, irq_out, irq_oe}, 8'h03);
      pin_ack = 0; repeat (3) @(negedge clk);
      check("R5 irq follows ack low", {7'd0, irq_out}, 8'h00);
      wr(2, 8'h00);
      pin_ack = 1; repeat (3) @(negedge clk);
      check("R5 irq disabled", {6'd0, irq_out, irq_oe}, 8'h01);
      pin_ack = 0; repeat (3) @(negedge clk);
   endtask

   task automatic t_sync();
      logic [7:0] v;
      @(negedge clk); pin_error = 1;
      @(posedge clk); #1;
      bus_addr = 1; bus_rd = 1; #1 v = bus_rdata; bus_rd = 0;
      check("R8 after one edge", v, 8'h80);
      @(posedge clk); #1;
      bus_addr = 1; bus_rd = 1; #1 v = bus_rdata; bus_rd = 0;
      check("R8 after two edges", v, 8'h88);
      pin_error = 0; repeat (3) @(negedge clk);
   endtask

   task automatic t_ignored();
      logic [7:0] v;
      wr(0, 8'h66); wr(2, 8'h44);
      wr(1, 8'hFF);
      rd(1, v); check("R9 status after write", v, 8'h80);
      check("R9 data after stat write", pd_out, 8'h66);
      rd(2, v); check("R9 ctrl after stat write", v, 8'h44);
      wr(3, 8'hFF); wr(15, 8'hAA);
      rd(3, v); check("R9 offset 3 reads 0", v, 8'h00);
      rd(15, v); check("R9 offset 15 reads 0", v, 8'h00);
      rd(2, v); check("R9 ctrl after high write", v, 8'h44);
      check("R9 pd_out after high write", pd_out, 8'h66);
      wr(2, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_out();
      t_dir_in();
      t_status();
      t_ctrl_pins();
      t_irq();
      t_sync();
      t_ignored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule